// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block is the control engine of one memory-read DMA channel. Software loads a descriptor table address and a total byte count, then writes the channel configuration word as all zeros to start the run. The engine reads one 16-byte descriptor at a time through a single-beat memory read port. It turns each descriptor into an address and length request for an external data mover. It waits until the mover reports that the segment has finished, and only then moves on to the next table slot.

A run ends normally after the segment whose descriptor carries the end-of-chain flag. A run ends in error when a descriptor has a zero length, or when the last permitted table slot completes without that flag. A running total of finished bytes is kept, along with the bytes still outstanding against the programmed total. Software can hold the channel paused, or force it back to idle with the clear bit.

Top module: `sgw_chain_walker`

## Requirements
- R1: After reset the configuration word reads zero, the completed-byte count and the remaining count are zero, and no memory read or segment request is raised.
- R2: A configuration write of value zero starts a run only when all of the following hold: the channel is idle, clear is not held, and both the low table address word (select 0) and the total length (select 2) have been written since the last start. Select 1 is the high address word and select 3 is the configuration word. A zero write made without those loads has no effect. Such a write neither sets the enable bit (bit 27) nor raises a memory read.
- R3: Table slot k is read at table address plus 16·k. The 128-bit read beat holds the control word in bits [31:0], the buffer address in bits [95:32] and reserved bits in [127:96]. The segment request carries the buffer address and the control bits [26:0] as its length, including the largest length 2^27−1. Control bits 29 and 31 have no effect.
- R4: Only one segment is outstanding at a time. No descriptor read is raised while the data mover still owes a completion. A request stays raised with a stable address and length until the mover accepts it.
- R5: The run ends after the segment whose control bit 28 is set. Ending raises a one-cycle done pulse, sets configuration bit 28 and drops the enable bit 27.
- R6: Each finished segment adds its length to the completed-byte count. The remaining output equals the programmed total minus that count.
- R7: A descriptor whose length field is zero ends the run with a one-cycle error pulse and sets the fault output. No request is issued for it, and the done bit stays clear.
- R8: A chain holds at most 8 descriptors. If slot 7 finishes without the end-of-chain bit, the run ends with an error pulse and no ninth read.
- R9: While configuration bit 26 (pause) is set, no new segment request is raised. A completion that arrives in the same cycle as the pause write is still counted. Writing zero while running resumes the run without restarting it.
- R10: A configuration write with bit 25 (clear) set returns the channel to idle at once. It zeroes the completed-byte count and the done bit, and raises neither pulse. This holds even when the final completion lands in the same cycle.
- R11: Finishing a segment whose control bit 27 is set raises a one-cycle segment interrupt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_we_i | input | 1 | Program write strobe |
| prog_sel_i | input | 2 | Write target: 0 table low, 1 table high, 2 total length, 3 configuration |
| prog_wdata_i | input | 32 | Write data |
| cfg_o | output | 32 | Configuration word: 25 clear, 26 pause, 27 enable, 28 done |
| done_bytes_o | output | 32 | Completed-byte count |
| remain_o | output | 32 | Programmed total minus completed bytes |
| fault_o | output | 1 | Last run ended in error |
| mrd_req_o | output | 1 | Descriptor read request |
| mrd_addr_o | output | 64 | Descriptor read address |
| mrd_ack_i | input | 1 | Read data valid |
| mrd_data_i | input | 128 | Descriptor beat |
| seg_valid_o | output | 1 | Segment request valid |
| seg_addr_o | output | 64 | Segment buffer address |
| seg_len_o | output | 27 | Segment byte length |
| seg_ready_i | input | 1 | Mover accepts the request |
| seg_done_i | input | 1 | Mover completed the accepted segment |
| done_pulse_o | output | 1 | One-cycle normal completion pulse |
| err_pulse_o | output | 1 | One-cycle error pulse |
| seg_irq_o | output | 1 | One-cycle per-segment interrupt pulse |

## Verification
Two pairs of events can meet in one cycle. The first is a configuration write that sets pause, landing in the cycle where the mover reports a segment finished. The second is a write that sets clear, landing in the cycle where the final end-of-chain segment finishes. The bench provokes both by waiting for the rising edge of its own completion strobe and driving the configuration write in that same half cycle, so that both arrive at one clock edge. It judges the pause case by the finished bytes being counted with no further request raised. It judges the clear case by the absence of a done pulse, together with a zero byte count and a clear done bit.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int AW        = 64;
  localparam int CW        = 32;
  localparam int LEN_W     = 27;
  localparam int SLOT_SH   = 4;

  localparam int CTL_IRQ   = 27;
  localparam int CTL_EOC   = 28;

  localparam int CFG_CLR   = 25;
  localparam int CFG_PAUSE = 26;
  localparam int CFG_EN    = 27;
  localparam int CFG_DONE  = 28;

  typedef enum logic [1:0] {
    PROG_TBL_LO = 2'd0,
    PROG_TBL_HI = 2'd1,
    PROG_TOTAL  = 2'd2,
    PROG_CFG    = 2'd3
  } prog_sel_e;

  typedef struct packed {
    logic [31:0]   rsvd;
    logic [AW-1:0] buf_addr;
    logic [31:0]   ctl;
  } sg_desc_t;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_FETCH = 2'd1,
    W_ISSUE = 2'd2,
    W_WAIT  = 2'd3
  } walk_st_e;

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] tbl, input logic [7:0] slot);
    return tbl + {{(AW-8-SLOT_SH){1'b0}}, slot, {SLOT_SH{1'b0}}};
  endfunction

  function automatic logic [LEN_W-1:0] ctl_len(input logic [31:0] ctl);
    return ctl[LEN_W-1:0];
  endfunction

  function automatic logic [CW-1:0] widen_len(input logic [LEN_W-1:0] len);
    return {{(CW-LEN_W){1'b0}}, len};
  endfunction

  function automatic logic [CW-1:0] bytes_left(input logic [CW-1:0] total, input logic [CW-1:0] done);
    return total - done;
  endfunction
endpackage

// File: rtl/sgw_regs.sv
module sgw_regs
  import sgw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we_i,
  input  logic [1:0]    prog_sel_i,
  input  logic [31:0]   prog_wdata_i,
  input  logic          busy_i,
  input  logic          fin_evt_i,
  input  logic          err_evt_i,
  output logic          start_o,
  output logic          pause_o,
  output logic          clear_o,
  output logic [AW-1:0] tbl_o,
  output logic [CW-1:0] total_o,
  output logic [31:0]   cfg_o,
  output logic          fault_o
);
  logic [AW-1:0] tbl_q;
  logic [CW-1:0] total_q;
  logic          tbl_ld_q, total_ld_q;
  logic          pause_q, clear_q, done_q, fault_q;
  logic          cfg_wr;

  assign cfg_wr  = prog_we_i && (prog_sel_i == PROG_CFG);
  assign start_o = cfg_wr && (prog_wdata_i == 32'd0) && !busy_i && !clear_q
                   && tbl_ld_q && total_ld_q;
  assign clear_o = cfg_wr ? prog_wdata_i[CFG_CLR] : clear_q;
  assign pause_o = pause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q      <= '0;
      total_q    <= '0;
      tbl_ld_q   <= 1'b0;
      total_ld_q <= 1'b0;
      pause_q    <= 1'b0;
      clear_q    <= 1'b0;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
    end else begin
      if (prog_we_i && prog_sel_i == PROG_TBL_LO) begin
        tbl_q[31:0] <= prog_wdata_i;
        tbl_ld_q    <= 1'b1;
      end
      if (prog_we_i && prog_sel_i == PROG_TBL_HI) tbl_q[AW-1:32] <= prog_wdata_i;
      if (prog_we_i && prog_sel_i == PROG_TOTAL) begin
        total_q    <= prog_wdata_i;
        total_ld_q <= 1'b1;
      end
      if (cfg_wr) begin
        pause_q <= prog_wdata_i[CFG_PAUSE];
        clear_q <= prog_wdata_i[CFG_CLR];
      end
      if (start_o) begin
        tbl_ld_q   <= 1'b0;
        total_ld_q <= 1'b0;
        done_q     <= 1'b0;
        fault_q    <= 1'b0;
      end else if (clear_o) begin
        done_q     <= 1'b0;
        fault_q    <= 1'b0;
      end else begin
        if (fin_evt_i) done_q  <= 1'b1;
        if (err_evt_i) fault_q <= 1'b1;
      end
    end
  end

  assign tbl_o   = tbl_q;
  assign total_o = total_q;
  assign fault_o = fault_q;

  always_comb begin
    cfg_o           = '0;
    cfg_o[CFG_CLR]  = clear_q;
    cfg_o[CFG_PAUSE]= pause_q;
    cfg_o[CFG_EN]   = busy_i;
    cfg_o[CFG_DONE] = done_q;
  end
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
  import sgw_pkg::*;
#(
  parameter int MAX_DESC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pause_i,
  input  logic             clear_i,
  input  logic [AW-1:0]    tbl_i,
  output logic             mrd_req_o,
  output logic [AW-1:0]    mrd_addr_o,
  input  logic             mrd_ack_i,
  input  logic [127:0]     mrd_data_i,
  output logic             seg_valid_o,
  output logic [AW-1:0]    seg_addr_o,
  output logic [LEN_W-1:0] seg_len_o,
  input  logic             seg_ready_i,
  input  logic             seg_done_i,
  output logic             busy_o,
  output logic             fin_evt_o,
  output logic             err_evt_o,
  output logic             cmp_evt_o,
  output logic [LEN_W-1:0] cmp_len_o,
  output logic             done_pulse_o,
  output logic             err_pulse_o,
  output logic             seg_irq_o
);
  localparam int IDX_W = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(MAX_DESC - 1);

  walk_st_e         st_q;
  logic [IDX_W-1:0] idx_q;
  logic [AW-1:0]    tbl_q;
  logic [AW-1:0]    cur_addr_q;
  logic [LEN_W-1:0] cur_len_q;
  logic             cur_eoc_q, cur_irq_q;
  sg_desc_t         rd_desc;
  logic             desc_unused;
  logic             fetch_hit, len_bad, seg_end, overrun, irq_evt;

  assign rd_desc     = sg_desc_t'(mrd_data_i);
  assign desc_unused = ^{rd_desc.rsvd, rd_desc.ctl[31:29]};

  assign mrd_req_o   = (st_q == W_FETCH);
  assign mrd_addr_o  = slot_addr(tbl_q, 8'(idx_q));
  assign seg_valid_o = (st_q == W_ISSUE) && !pause_i && !clear_i;
  assign seg_addr_o  = cur_addr_q;
  assign seg_len_o   = cur_len_q;
  assign busy_o      = (st_q != W_IDLE);

  assign fetch_hit = (st_q == W_FETCH) && mrd_ack_i && !clear_i;
  assign len_bad   = fetch_hit && (ctl_len(rd_desc.ctl) == '0);
  assign seg_end   = (st_q == W_WAIT) && seg_done_i && !clear_i;
  assign overrun   = seg_end && !cur_eoc_q && (idx_q == LAST_SLOT);
  assign fin_evt_o = seg_end && cur_eoc_q;
  assign err_evt_o = len_bad || overrun;
  assign cmp_evt_o = seg_end;
  assign cmp_len_o = cur_len_q;
  assign irq_evt   = seg_end && cur_irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= W_IDLE;
      idx_q      <= '0;
      tbl_q      <= '0;
      cur_addr_q <= '0;
      cur_len_q  <= '0;
      cur_eoc_q  <= 1'b0;
      cur_irq_q  <= 1'b0;
    end else if (clear_i) begin
      st_q <= W_IDLE;
    end else begin
      unique case (st_q)
        W_IDLE: if (start_i) begin
          tbl_q <= tbl_i;
          idx_q <= '0;
          st_q  <= W_FETCH;
        end
        W_FETCH: if (mrd_ack_i) begin
          cur_addr_q <= rd_desc.buf_addr;
          cur_len_q  <= ctl_len(rd_desc.ctl);
          cur_eoc_q  <= rd_desc.ctl[CTL_EOC];
          cur_irq_q  <= rd_desc.ctl[CTL_IRQ];
          st_q       <= len_bad ? W_IDLE : W_ISSUE;
        end
        W_ISSUE: if (seg_valid_o && seg_ready_i) st_q <= W_WAIT;
        W_WAIT: if (seg_done_i) begin
          if (cur_eoc_q || idx_q == LAST_SLOT) begin
            st_q <= W_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= W_FETCH;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_pulse_o <= 1'b0;
      err_pulse_o  <= 1'b0;
      seg_irq_o    <= 1'b0;
    end else begin
      done_pulse_o <= fin_evt_o;
      err_pulse_o  <= err_evt_o;
      seg_irq_o    <= irq_evt;
    end
  end
endmodule

// File: rtl/sgw_bytecnt.sv
module sgw_bytecnt
  import sgw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero_i,
  input  logic             add_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CW-1:0]    count_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_o <= '0;
    else if (zero_i) count_o <= '0;
    else if (add_i)  count_o <= count_o + widen_len(len_i);
  end
endmodule

// File: rtl/sgw_chain_walker.sv
module sgw_chain_walker
  import sgw_pkg::*;
#(
  parameter int MAX_DESC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we_i,
  input  logic [1:0]    prog_sel_i,
  input  logic [31:0]   prog_wdata_i,
  output logic [31:0]   cfg_o,
  output logic [31:0]   done_bytes_o,
  output logic [31:0]   remain_o,
  output logic          fault_o,
  output logic          mrd_req_o,
  output logic [63:0]   mrd_addr_o,
  input  logic          mrd_ack_i,
  input  logic [127:0]  mrd_data_i,
  output logic          seg_valid_o,
  output logic [63:0]   seg_addr_o,
  output logic [26:0]   seg_len_o,
  input  logic          seg_ready_i,
  input  logic          seg_done_i,
  output logic          done_pulse_o,
  output logic          err_pulse_o,
  output logic          seg_irq_o
);
  logic             start, pause, clear, busy;
  logic             fin_evt, err_evt, cmp_evt;
  logic [LEN_W-1:0] cmp_len;
  logic [AW-1:0]    tbl;
  logic [CW-1:0]    total;

  sgw_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .prog_we_i(prog_we_i), .prog_sel_i(prog_sel_i), .prog_wdata_i(prog_wdata_i),
    .busy_i(busy), .fin_evt_i(fin_evt), .err_evt_i(err_evt),
    .start_o(start), .pause_o(pause), .clear_o(clear),
    .tbl_o(tbl), .total_o(total), .cfg_o(cfg_o), .fault_o(fault_o)
  );

  sgw_walker #(.MAX_DESC(MAX_DESC)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .pause_i(pause), .clear_i(clear), .tbl_i(tbl),
    .mrd_req_o(mrd_req_o), .mrd_addr_o(mrd_addr_o),
    .mrd_ack_i(mrd_ack_i), .mrd_data_i(mrd_data_i),
    .seg_valid_o(seg_valid_o), .seg_addr_o(seg_addr_o), .seg_len_o(seg_len_o),
    .seg_ready_i(seg_ready_i), .seg_done_i(seg_done_i),
    .busy_o(busy), .fin_evt_o(fin_evt), .err_evt_o(err_evt),
    .cmp_evt_o(cmp_evt), .cmp_len_o(cmp_len),
    .done_pulse_o(done_pulse_o), .err_pulse_o(err_pulse_o), .seg_irq_o(seg_irq_o)
  );

  sgw_bytecnt u_cnt (
    .clk(clk), .rst_n(rst_n),
    .zero_i(clear || start), .add_i(cmp_evt), .len_i(cmp_len),
    .count_o(done_bytes_o)
  );

  assign remain_o = bytes_left(total, done_bytes_o);
endmodule

// File: rtl/sgw_chain_walker_chk.sv
module sgw_chain_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cfg_o,
  input logic [31:0] done_bytes_o,
  input logic        mrd_req_o,
  input logic        seg_valid_o,
  input logic        seg_ready_i,
  input logic [63:0] seg_addr_o,
  input logic [26:0] seg_len_o,
  input logic        done_pulse_o,
  input logic        err_pulse_o
);
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid_o && !seg_ready_i |=> $stable(seg_addr_o) && $stable(seg_len_o)
                                    && (seg_valid_o || cfg_o[26] || cfg_o[25]));
  a_r5_done_bit: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse_o |-> cfg_o[28] && !cfg_o[27]);
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse_o |=> !done_pulse_o);
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse_o |-> !seg_valid_o && !mrd_req_o);
  a_r9_pause_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[26] |-> !seg_valid_o);
  a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[25] |=> done_bytes_o == 32'd0);
  a_r10_clear_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[25] |-> !done_pulse_o && !err_pulse_o);
endmodule

bind sgw_chain_walker sgw_chain_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_o(cfg_o), .done_bytes_o(done_bytes_o),
  .mrd_req_o(mrd_req_o), .seg_valid_o(seg_valid_o), .seg_ready_i(seg_ready_i),
  .seg_addr_o(seg_addr_o), .seg_len_o(seg_len_o),
  .done_pulse_o(done_pulse_o), .err_pulse_o(err_pulse_o)
);

// File: tb/sgw_chain_walker_tb.sv
module sgw_chain_walker_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_we = 1'b0; logic [1:0] prog_sel = '0; logic [31:0] prog_wdata = '0;
  logic [31:0] cfg, done_bytes, remain; logic fault;
  logic mrd_req; logic [63:0] mrd_addr; logic mrd_ack = 1'b0; logic [127:0] mrd_data = '0;
  logic seg_valid; logic [63:0] seg_addr; logic [26:0] seg_len;
  logic seg_ready = 1'b0, seg_done = 1'b0;
  logic done_pulse, err_pulse, seg_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgw_chain_walker u_dut (
    .clk(clk), .rst_n(rst_n), .prog_we_i(prog_we), .prog_sel_i(prog_sel), .prog_wdata_i(prog_wdata),
    .cfg_o(cfg), .done_bytes_o(done_bytes), .remain_o(remain), .fault_o(fault),
    .mrd_req_o(mrd_req), .mrd_addr_o(mrd_addr), .mrd_ack_i(mrd_ack), .mrd_data_i(mrd_data),
    .seg_valid_o(seg_valid), .seg_addr_o(seg_addr), .seg_len_o(seg_len),
    .seg_ready_i(seg_ready), .seg_done_i(seg_done),
    .done_pulse_o(done_pulse), .err_pulse_o(err_pulse), .seg_irq_o(seg_irq)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [127:0] mem [0:15];
  logic [63:0] tbl_base = '0;
  int n_fetch = 0, n_hs = 0, n_done = 0, n_err = 0, n_irq = 0, n_viol = 0;
  logic [63:0] log_addr [0:255]; logic [26:0] log_len [0:255];
  logic [63:0] first_fetch = '0;
  logic mv_busy = 1'b0, hs_pend = 1'b0; int mv_cnt = 0;
  logic [63:0] pa = '0; logic [26:0] pl = '0;

  // descriptor memory model: one-cycle ack
  always @(negedge clk) begin
    if (mrd_ack) mrd_ack = 1'b0;
    else if (mrd_req) begin
      if (mv_busy || hs_pend) n_viol++;
      if (n_fetch == 0) first_fetch = mrd_addr;
      mrd_data = ((mrd_addr - tbl_base) >> 4) < 16 ? mem[4'((mrd_addr - tbl_base) >> 4)] : '0;
      mrd_ack = 1'b1;
      n_fetch++;
    end
  end

  // data mover model
  always @(negedge clk) begin
    seg_done = 1'b0;
    if (hs_pend) begin
      log_addr[n_hs % 256] = pa; log_len[n_hs % 256] = pl; n_hs++;
      mv_busy = 1'b1; mv_cnt = 1 + int'($urandom % 4); hs_pend = 1'b0;
    end else if (mv_busy) begin
      mv_cnt--;
      if (mv_cnt == 0) begin seg_done = 1'b1; mv_busy = 1'b0; end
    end
    seg_ready = !mv_busy && ($urandom % 3 != 0);
    hs_pend = seg_valid && seg_ready;
    if (hs_pend) begin pa = seg_addr; pl = seg_len; end
  end

  always @(negedge clk) begin
    cyc++;
    if (done_pulse) n_done++;
    if (err_pulse) n_err++;
    if (seg_irq) n_irq++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    prog_we = 1'b1; prog_sel = sel; prog_wdata = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  logic [63:0] e_addr [0:7]; logic [26:0] e_len [0:7];
  longint e_sum; int e_irq, e_segs;

  // fill a chain; eoc_at<0 means no end flag, zero_at>=0 forces a zero length
  task automatic build(input int n, input int eoc_at, input int zero_at, input bit maxlen);
    logic [31:0] ctl; logic [26:0] l; bit irq;
    tbl_base = {$urandom, $urandom & 32'hFFFF_FFF0};
    e_sum = 0; e_irq = 0; e_segs = 0;
    for (int k = 0; k < 16; k++) mem[k] = '0;
    for (int k = 0; k < n; k++) begin
      l = maxlen ? 27'h7FF_FFFF : 27'(($urandom % 32'h7FF_FFFE) + 1);
      if (k == zero_at) l = '0;
      irq = $urandom % 2 == 1;
      ctl = {1'($urandom), 1'b0, 1'($urandom), (k == eoc_at), irq, l};
      e_addr[k] = {$urandom, $urandom}; e_len[k] = l;
      mem[k] = {32'h0, e_addr[k], ctl};
      if ((zero_at < 0 || k < zero_at) && (eoc_at < 0 || k <= eoc_at)) begin
        e_sum += longint'(l); e_irq += int'(irq); e_segs++;
      end
    end
  endtask

  task automatic launch(input logic [31:0] total);
    wr(2'd0, tbl_base[31:0]); wr(2'd1, tbl_base[63:32]); wr(2'd2, total); wr(2'd3, 32'd0);
  endtask

  task automatic wait_end(input int d0, input int e0);
    int k = 0;
    while (n_done == d0 && n_err == e0 && k < 3000) begin @(negedge clk); k++; end
    if (k >= 3000) begin n_chk++; n_fail++; $display("FAIL R5 run did not end actual=0 expected=1"); end
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_hs(input int target);
    int k = 0;
    while (n_hs < target && k < 3000) begin @(negedge clk); k++; end
  endtask

  task automatic run_check(input string tag, input int h0, input int i0, input logic [31:0] total);
    for (int k = 0; k < e_segs; k++) begin
      chk({tag, " R3 seg addr"}, log_addr[(h0 + k) % 256], e_addr[k]);
      chk({tag, " R3 seg len"}, 64'(log_len[(h0 + k) % 256]), 64'(e_len[k]));
    end
    chk({tag, " R6 done bytes"}, 64'(done_bytes), 64'(e_sum[31:0]));
    chk({tag, " R6 remaining"}, 64'(remain), 64'(total - e_sum[31:0]));
    chk({tag, " R11 irq count"}, 64'(n_irq - i0), 64'(e_irq));
  endtask

  initial begin
    int h0, d0, e0, f0, i0; logic [31:0] tot;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cfg reset", 64'(cfg), 64'h0);
    chk("R1 bytes reset", 64'(done_bytes), 64'h0);
    chk("R1 remain reset", 64'(remain), 64'h0);
    chk("R1 no requests", 64'({mrd_req, seg_valid}), 64'h0);

    // R2: zero write without loads, then with base only
    wr(2'd3, 32'd0); repeat (5) @(negedge clk);
    chk("R2 no start unloaded", 64'({cfg[27], 31'(n_fetch)}), 64'h0);
    build(2, 1, -1, 1'b0);
    wr(2'd0, tbl_base[31:0]); wr(2'd1, tbl_base[63:32]); wr(2'd3, 32'd0); repeat (5) @(negedge clk);
    chk("R2 no start without length", 64'(n_fetch), 64'h0);
    d0 = n_done; e0 = n_err; h0 = n_hs; i0 = n_irq; tot = e_sum[31:0] + 32'd100;
    wr(2'd2, tot); wr(2'd3, 32'd0);
    @(negedge clk);
    chk("R2 enable after start", 64'(cfg[27]), 64'h1);
    wait_end(d0, e0);
    chk("R3 first slot address", first_fetch, tbl_base);
    chk("R5 done pulse once", 64'(n_done - d0), 64'h1);
    chk("R5 cfg done set enable clear", 64'({cfg[28], cfg[27]}), 64'h2);
    run_check("directed", h0, i0, tot);

    // R3: largest segment length
    build(1, 0, -1, 1'b1);
    d0 = n_done; e0 = n_err; h0 = n_hs; i0 = n_irq; tot = 32'hFFFF_FFFF;
    launch(tot); wait_end(d0, e0);
    run_check("maxlen", h0, i0, tot);

    // random chains, R3 R4 R5 R6 R11
    for (int it = 0; it < 12; it++) begin
      int n = 1 + int'($urandom % 8);
      build(n, n - 1, -1, 1'b0);
      d0 = n_done; e0 = n_err; h0 = n_hs; i0 = n_irq; f0 = n_fetch;
      tot = e_sum[31:0] + ($urandom % 5000);
      launch(tot); wait_end(d0, e0);
      chk("R5 random single done", 64'({n_done - d0, n_err - e0}), 64'({32'd1, 32'd0}));
      chk("R4 fetch per segment", 64'(n_fetch - f0), 64'(n));
      run_check("random", h0, i0, tot);
    end
    chk("R4 no read while segment owed", 64'(n_viol), 64'h0);

    // R7 zero length at slot 2
    build(4, 3, 2, 1'b0);
    d0 = n_done; e0 = n_err; h0 = n_hs; i0 = n_irq; tot = e_sum[31:0];
    launch(tot); wait_end(d0, e0);
    chk("R7 error pulse", 64'({n_err - e0, n_done - d0}), 64'({32'd1, 32'd0}));
    chk("R7 segments before error", 64'(n_hs - h0), 64'h2);
    chk("R7 fault set done clear", 64'({fault, cfg[28]}), 64'h2);
    run_check("zerolen", h0, i0, tot);

    // R8 eight slots, none with end flag
    build(8, -1, -1, 1'b0);
    d0 = n_done; e0 = n_err; h0 = n_hs; i0 = n_irq; f0 = n_fetch; tot = e_sum[31:0];
    launch(tot); wait_end(d0, e0);
    chk("R8 overrun error", 64'({n_err - e0, n_done - d0}), 64'({32'd1, 32'd0}));
    chk("R8 no ninth read", 64'(n_fetch - f0), 64'h8);
    chk("R8 fault", 64'(fault), 64'h1);
    run_check("overrun", h0, i0, tot);

    // R9 pause write lands with a segment completion
    build(3, 2, -1, 1'b0);
    d0 = n_done; e0 = n_err; h0 = n_hs; i0 = n_irq; tot = e_sum[31:0];
    launch(tot); wait_hs(h0 + 1);
    @(posedge seg_done);
    wr(2'd3, 32'h1 << 26);
    repeat (30) @(negedge clk);
    chk("R9 no request while paused", 64'(n_hs - h0), 64'h1);
    chk("R9 completion counted", 64'(done_bytes), 64'(e_len[0]));
    chk("R9 paused and enabled", 64'({cfg[27], cfg[26]}), 64'h3);
    wr(2'd3, 32'd0); wait_end(d0, e0);
    chk("R9 resumed to end", 64'(n_done - d0), 64'h1);
    run_check("pause", h0, i0, tot);

    // R10 clear write lands with final completion
    build(2, 1, -1, 1'b0);
    d0 = n_done; e0 = n_err; h0 = n_hs; tot = e_sum[31:0];
    launch(tot); wait_hs(h0 + 2);
    @(posedge seg_done);
    wr(2'd3, 32'h1 << 25);
    repeat (10) @(negedge clk);
    chk("R10 no pulse on clear", 64'({n_done - d0, n_err - e0}), 64'h0);
    chk("R10 bytes zeroed", 64'(done_bytes), 64'h0);
    chk("R10 cfg idle", 64'({cfg[28], cfg[27], cfg[25]}), 64'h1);
    wr(2'd3, 32'd0);
    build(3, 2, -1, 1'b0);
    d0 = n_done; e0 = n_err; h0 = n_hs; i0 = n_irq; tot = e_sum[31:0];
    launch(tot); wait_end(d0, e0);
    chk("R10 runs after release", 64'(n_done - d0), 64'h1);
    run_check("after clear", h0, i0, tot);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule